// File: doc/BRIEF.md
# Exception Entry and Vector Unit

This block takes one exception request per clock, works out where the processor must go next, and decides which return-address register and which status and cause fields that request changes. The request carries a 5-bit kind code, the program counter of the faulting instruction, a flag saying the instruction sits in a branch delay slot, and a flag that marks a TLB miss as a refill. The live processor status arrives on plain inputs: exception level, error level, bootstrap vectors, debug mode and interrupt-vector select. A vector base register value also arrives as an input.

Three families of request exist. General exceptions write the exception PC and the cause code, and they set the exception level. Non-maskable interrupt and soft reset write the error PC and jump to the reset vector. Debug requests write the debug PC and jump to the debug vector. All results are registered, so they appear one clock after the strobe. Outside an accepted request every output holds its value.

Top module: `exc_entry_unit`

## Requirements
- R1: A general exception taken while stat_exl_i is 0 loads epc_o with cur_pc_i, or with cur_pc_i-4 when in_dslot_i is 1. It sets bd_o equal to in_dslot_i and sets exl_o to 1. erl_o, bev_o and dm_o copy their status inputs.
- R2: A general exception taken while stat_exl_i is 1 leaves epc_o and bd_o unchanged, and exl_o stays 1.
- R3: The general vector is a base plus an offset. The base is 0xBFC00200 when stat_bev_i is 1. Otherwise it is vec_base_i (address bits 31..10) with the low 10 bits zero. The default offset is 0x180.
- R4: An interrupt (kind 0) taken while intvec_i is 1 uses offset 0x200.
- R5: TLB load (kind 2) and TLB store (kind 3) with refill_i=1 and stat_exl_i=0 use offset 0x000. With stat_exl_i=1 they use 0x180.
- R6: Cache error (kind 30) uses offset 0x100 when stat_bev_i is 1 and 0x20000100 otherwise.
- R7: General kinds are 0 to 13, 15, 23, 24 and 30, and the kind value is the cause code. These are: 0 interrupt, 1 TLB modify, 2 TLB load, 3 TLB store, 4 address error load, 5 address error store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating point, 23 watch, 24 machine check, 30 cache error. code_o takes the kind on every general exception, whatever the exception level.
- R8: Kind 16 (non-maskable interrupt) and kind 17 (soft reset) load errpc_o with cur_pc_i, or cur_pc_i-4 in a delay slot. They set erl_o and bev_o to 1 and load next_pc_o with 0xBFC00000. epc_o, bd_o and code_o are unchanged. exl_o and dm_o copy their inputs.
- R9: Kind 18 (debug) loads dpc_o with cur_pc_i, or cur_pc_i-4 in a delay slot. It sets dm_o to 1 and loads next_pc_o with 0xBFC00480. epc_o, errpc_o, bd_o and code_o are unchanged.
- R10: A strobe with any other kind (14, 19 to 22, 25 to 29, 31) changes no output, and taken_o stays 0.
- R11: Results appear at the first clock edge after the strobe, and taken_o is high for exactly that one cycle. After reset, next_pc_o is 0xBFC00000, erl_o and bev_o are 1, and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_valid_i | input | 1 | Exception request strobe |
| exc_kind_i | input | 5 | Exception kind code |
| cur_pc_i | input | PCW | PC of the faulting instruction |
| in_dslot_i | input | 1 | Faulting instruction is in a delay slot |
| refill_i | input | 1 | TLB miss is a refill |
| stat_exl_i | input | 1 | Current exception level |
| stat_erl_i | input | 1 | Current error level |
| stat_bev_i | input | 1 | Current bootstrap-vector flag |
| stat_dm_i | input | 1 | Current debug mode |
| intvec_i | input | 1 | Interrupts use the dedicated vector |
| vec_base_i | input | PCW-BASE_LSB | Exception base, upper bits |
| taken_o | output | 1 | Pulse: a request was accepted |
| next_pc_o | output | PCW | Vector to fetch from |
| epc_o | output | PCW | Exception return address |
| errpc_o | output | PCW | Error return address |
| dpc_o | output | PCW | Debug return address |
| exl_o | output | 1 | Updated exception level |
| erl_o | output | 1 | Updated error level |
| bev_o | output | 1 | Updated bootstrap flag |
| dm_o | output | 1 | Updated debug mode |
| bd_o | output | 1 | Branch-delay cause bit |
| code_o | output | 5 | Cause code |

## Verification
The bench builds the block with PCW=32, BASE_LSB=10 and the default vector constants. With these values the 0x20000100 cache-error offset and the top-bit carry of a base plus offset are both exercised. A PC of zero in a delay slot wraps to 0xFFFFFFFC, and the bench forces this case often. All 32 kind codes and every combination of the status inputs are reached, so unknown kinds, refills at both exception levels and repeated exceptions above an already raised level are all exercised.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int KIND_W = 5;
    localparam int CODE_W = 5;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_GENERAL,
        CLS_ERROR,
        CLS_DEBUG
    } exc_cls_e;

    localparam logic [KIND_W-1:0] K_INTR     = 5'd0;
    localparam logic [KIND_W-1:0] K_TLB_MOD  = 5'd1;
    localparam logic [KIND_W-1:0] K_TLB_LD   = 5'd2;
    localparam logic [KIND_W-1:0] K_TLB_ST   = 5'd3;
    localparam logic [KIND_W-1:0] K_ADR_LD   = 5'd4;
    localparam logic [KIND_W-1:0] K_ADR_ST   = 5'd5;
    localparam logic [KIND_W-1:0] K_IBUS     = 5'd6;
    localparam logic [KIND_W-1:0] K_DBUS     = 5'd7;
    localparam logic [KIND_W-1:0] K_SYSC     = 5'd8;
    localparam logic [KIND_W-1:0] K_BRK      = 5'd9;
    localparam logic [KIND_W-1:0] K_RSVD     = 5'd10;
    localparam logic [KIND_W-1:0] K_COPU     = 5'd11;
    localparam logic [KIND_W-1:0] K_OVF      = 5'd12;
    localparam logic [KIND_W-1:0] K_TRAP     = 5'd13;
    localparam logic [KIND_W-1:0] K_FPU      = 5'd15;
    localparam logic [KIND_W-1:0] K_NMI      = 5'd16;
    localparam logic [KIND_W-1:0] K_SRST     = 5'd17;
    localparam logic [KIND_W-1:0] K_DEBUG    = 5'd18;
    localparam logic [KIND_W-1:0] K_WATCH    = 5'd23;
    localparam logic [KIND_W-1:0] K_MCHK     = 5'd24;
    localparam logic [KIND_W-1:0] K_CACHE    = 5'd30;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
    import exc_entry_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    output exc_cls_e          cls_o,
    output logic [CODE_W-1:0] code_o,
    output logic              intr_o,
    output logic              tlb_ls_o,
    output logic              cache_o
);

    always_comb begin
        cls_o    = CLS_NONE;
        code_o   = CODE_W'(kind_i);
        intr_o   = 1'b0;
        tlb_ls_o = 1'b0;
        cache_o  = 1'b0;
        case (kind_i)
            K_INTR: begin
                cls_o  = CLS_GENERAL;
                intr_o = 1'b1;
            end
            K_TLB_LD, K_TLB_ST: begin
                cls_o    = CLS_GENERAL;
                tlb_ls_o = 1'b1;
            end
            K_CACHE: begin
                cls_o   = CLS_GENERAL;
                cache_o = 1'b1;
            end
            K_TLB_MOD, K_ADR_LD, K_ADR_ST, K_IBUS, K_DBUS, K_SYSC, K_BRK,
            K_RSVD, K_COPU, K_OVF, K_TRAP, K_FPU, K_WATCH, K_MCHK:
                cls_o = CLS_GENERAL;
            K_NMI, K_SRST:
                cls_o = CLS_ERROR;
            K_DEBUG:
                cls_o = CLS_DEBUG;
            default:
                cls_o = CLS_NONE;
        endcase
    end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
    parameter int               PCW          = 32,
    parameter int               BASE_LSB     = 10,
    parameter logic [PCW-1:0]   BOOT_GEN_VEC = PCW'(32'hBFC0_0200)
) (
    input  logic                    bev_i,
    input  logic [PCW-1:BASE_LSB]   base_i,
    input  logic                    iv_i,
    input  logic                    exl_i,
    input  logic                    refill_i,
    input  logic                    intr_i,
    input  logic                    tlb_ls_i,
    input  logic                    cache_i,
    output logic [PCW-1:0]          vec_o
);

    localparam logic [PCW-1:0] OFF_GENERAL   = PCW'(32'h0000_0180);
    localparam logic [PCW-1:0] OFF_INTVEC    = PCW'(32'h0000_0200);
    localparam logic [PCW-1:0] OFF_REFILL    = PCW'(32'h0000_0000);
    localparam logic [PCW-1:0] OFF_CACHE_BT  = PCW'(32'h0000_0100);
    localparam logic [PCW-1:0] OFF_CACHE_RUN = PCW'(32'h2000_0100);

    logic [PCW-1:0] base_sel;
    logic [PCW-1:0] offset_sel;

    always_comb begin
        if (bev_i) begin
            base_sel = BOOT_GEN_VEC;
        end else begin
            base_sel = {base_i, {BASE_LSB{1'b0}}};
        end

        if (cache_i) begin
            offset_sel = bev_i ? OFF_CACHE_BT : OFF_CACHE_RUN;
        end else if (intr_i && iv_i) begin
            offset_sel = OFF_INTVEC;
        end else if (tlb_ls_i && refill_i && !exl_i) begin
            offset_sel = OFF_REFILL;
        end else begin
            offset_sel = OFF_GENERAL;
        end

        vec_o = base_sel + offset_sel;
    end

endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
    parameter int PCW        = 32,
    parameter int SLOT_BYTES = 4
) (
    input  logic [PCW-1:0] pc_i,
    input  logic           dslot_i,
    output logic [PCW-1:0] ret_o
);

    localparam logic [PCW-1:0] SLOT_STEP = PCW'(SLOT_BYTES);

    always_comb begin
        ret_o = dslot_i ? (pc_i - SLOT_STEP) : pc_i;
    end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_entry_pkg::*;
#(
    parameter int             PCW          = 32,
    parameter int             BASE_LSB     = 10,
    parameter int             SLOT_BYTES   = 4,
    parameter logic [PCW-1:0] RESET_VEC    = PCW'(32'hBFC0_0000),
    parameter logic [PCW-1:0] BOOT_GEN_VEC = PCW'(32'hBFC0_0200),
    parameter logic [PCW-1:0] DEBUG_VEC    = PCW'(32'hBFC0_0480)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  exc_valid_i,
    input  logic [4:0]            exc_kind_i,
    input  logic [PCW-1:0]        cur_pc_i,
    input  logic                  in_dslot_i,
    input  logic                  refill_i,
    input  logic                  stat_exl_i,
    input  logic                  stat_erl_i,
    input  logic                  stat_bev_i,
    input  logic                  stat_dm_i,
    input  logic                  intvec_i,
    input  logic [PCW-1:BASE_LSB] vec_base_i,
    output logic                  taken_o,
    output logic [PCW-1:0]        next_pc_o,
    output logic [PCW-1:0]        epc_o,
    output logic [PCW-1:0]        errpc_o,
    output logic [PCW-1:0]        dpc_o,
    output logic                  exl_o,
    output logic                  erl_o,
    output logic                  bev_o,
    output logic                  dm_o,
    output logic                  bd_o,
    output logic [4:0]            code_o
);

    typedef struct packed {
        logic              taken;
        logic [PCW-1:0]    npc;
        logic [PCW-1:0]    epc;
        logic [PCW-1:0]    errpc;
        logic [PCW-1:0]    dpc;
        logic              exl;
        logic              erl;
        logic              bev;
        logic              dm;
        logic              bd;
        logic [CODE_W-1:0] code;
    } ent_state_t;

    exc_cls_e          cls;
    logic [CODE_W-1:0] kind_code;
    logic              is_intr;
    logic              is_tlb_ls;
    logic              is_cache;
    logic [PCW-1:0]    gen_vec;
    logic [PCW-1:0]    ret_pc;

    ent_state_t st_d;
    ent_state_t st_q;

    exc_classify u_cls (
        .kind_i   (exc_kind_i),
        .cls_o    (cls),
        .code_o   (kind_code),
        .intr_o   (is_intr),
        .tlb_ls_o (is_tlb_ls),
        .cache_o  (is_cache)
    );

    exc_vector_sel #(
        .PCW          (PCW),
        .BASE_LSB     (BASE_LSB),
        .BOOT_GEN_VEC (BOOT_GEN_VEC)
    ) u_vec (
        .bev_i    (stat_bev_i),
        .base_i   (vec_base_i),
        .iv_i     (intvec_i),
        .exl_i    (stat_exl_i),
        .refill_i (refill_i),
        .intr_i   (is_intr),
        .tlb_ls_i (is_tlb_ls),
        .cache_i  (is_cache),
        .vec_o    (gen_vec)
    );

    exc_ret_addr #(
        .PCW        (PCW),
        .SLOT_BYTES (SLOT_BYTES)
    ) u_ret (
        .pc_i    (cur_pc_i),
        .dslot_i (in_dslot_i),
        .ret_o   (ret_pc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        if (exc_valid_i) begin
            case (cls)
                CLS_GENERAL: begin
                    st_d.taken = 1'b1;
                    st_d.npc   = gen_vec;
                    st_d.code  = kind_code;
                    if (!stat_exl_i) begin
                        st_d.epc = ret_pc;
                        st_d.bd  = in_dslot_i;
                    end
                    st_d.exl = 1'b1;
                    st_d.erl = stat_erl_i;
                    st_d.bev = stat_bev_i;
                    st_d.dm  = stat_dm_i;
                end
                CLS_ERROR: begin
                    st_d.taken = 1'b1;
                    st_d.npc   = RESET_VEC;
                    st_d.errpc = ret_pc;
                    st_d.exl   = stat_exl_i;
                    st_d.erl   = 1'b1;
                    st_d.bev   = 1'b1;
                    st_d.dm    = stat_dm_i;
                end
                CLS_DEBUG: begin
                    st_d.taken = 1'b1;
                    st_d.npc   = DEBUG_VEC;
                    st_d.dpc   = ret_pc;
                    st_d.exl   = stat_exl_i;
                    st_d.erl   = stat_erl_i;
                    st_d.bev   = stat_bev_i;
                    st_d.dm    = 1'b1;
                end
                default: begin
                    st_d.taken = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.npc   <= RESET_VEC;
            st_q.erl   <= 1'b1;
            st_q.bev   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign taken_o   = st_q.taken;
    assign next_pc_o = st_q.npc;
    assign epc_o     = st_q.epc;
    assign errpc_o   = st_q.errpc;
    assign dpc_o     = st_q.dpc;
    assign exl_o     = st_q.exl;
    assign erl_o     = st_q.erl;
    assign bev_o     = st_q.bev;
    assign dm_o      = st_q.dm;
    assign bd_o      = st_q.bd;
    assign code_o    = st_q.code;

    // R1: a general exception always leaves the exception level raised
    a_r1_exl_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && cls == CLS_GENERAL) |=> (exl_o && taken_o));

    // R2: return address and delay bit frozen above the exception level
    a_r2_epc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && cls == CLS_GENERAL && stat_exl_i) |=> ($stable(epc_o) && $stable(bd_o)));

    // R8: error-class entry goes to the reset vector with both flags set
    a_r8_error_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && cls == CLS_ERROR) |=> (next_pc_o == RESET_VEC && erl_o && bev_o && $stable(epc_o)));

    // R9: debug entry goes to the debug vector in debug mode
    a_r9_debug_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && cls == CLS_DEBUG) |=> (next_pc_o == DEBUG_VEC && dm_o && $stable(errpc_o)));

    // R10: an unknown kind leaves every result untouched
    a_r10_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid_i && cls == CLS_NONE) |=> (!taken_o && $stable(next_pc_o) && $stable(epc_o) && $stable(code_o)));

    // R11: no strobe, no pulse
    a_r11_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_valid_i) |=> !taken_o);

endmodule

// File: tb/sim_exc_entry_unit.sv
`timescale 1ns/1ps
module sim_exc_entry_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid_i = 1'b0;
    logic [4:0]  exc_kind_i = '0;
    logic [31:0] cur_pc_i = '0;
    logic        in_dslot_i = 1'b0;
    logic        refill_i = 1'b0;
    logic        stat_exl_i = 1'b0;
    logic        stat_erl_i = 1'b0;
    logic        stat_bev_i = 1'b0;
    logic        stat_dm_i = 1'b0;
    logic        intvec_i = 1'b0;
    logic [31:10] vec_base_i = '0;

    logic        taken_o;
    logic [31:0] next_pc_o, epc_o, errpc_o, dpc_o;
    logic        exl_o, erl_o, bev_o, dm_o, bd_o;
    logic [4:0]  code_o;

    always #5 clk = ~clk;

    exc_entry_unit u0 (
        .clk(clk), .rst_n(rst_n), .exc_valid_i(exc_valid_i), .exc_kind_i(exc_kind_i),
        .cur_pc_i(cur_pc_i), .in_dslot_i(in_dslot_i), .refill_i(refill_i),
        .stat_exl_i(stat_exl_i), .stat_erl_i(stat_erl_i), .stat_bev_i(stat_bev_i),
        .stat_dm_i(stat_dm_i), .intvec_i(intvec_i), .vec_base_i(vec_base_i),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .epc_o(epc_o), .errpc_o(errpc_o),
        .dpc_o(dpc_o), .exl_o(exl_o), .erl_o(erl_o), .bev_o(bev_o), .dm_o(dm_o),
        .bd_o(bd_o), .code_o(code_o)
    );

    // reference model
    logic        m_taken;
    logic [31:0] m_pc, m_epc, m_errpc, m_dpc;
    logic        m_exl, m_erl, m_bev, m_dm, m_bd;
    logic [4:0]  m_code;
    string       m_tag;
    string       m_pc_tag;

    function automatic bit is_general(input int k);
        return (k <= 13) || k == 15 || k == 23 || k == 24 || k == 30;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_taken <= 0; m_pc <= 32'hBFC00000; m_epc <= 0; m_errpc <= 0; m_dpc <= 0;
            m_exl <= 0; m_erl <= 1; m_bev <= 1; m_dm <= 0; m_bd <= 0; m_code <= 0;
            m_tag <= "R11"; m_pc_tag <= "R11";
        end else begin
            m_taken <= 0;
            m_tag <= "R10";
            m_pc_tag <= "R10";
            if (exc_valid_i) begin
                int k;
                logic [31:0] ra, base, off;
                k = int'(exc_kind_i);
                ra = in_dslot_i ? cur_pc_i - 32'd4 : cur_pc_i;
                if (is_general(k)) begin
                    base = stat_bev_i ? 32'hBFC00200 : {vec_base_i, 10'h0};
                    if (k == 30) begin
                        off = stat_bev_i ? 32'h100 : 32'h20000100;
                        m_pc_tag <= "R6";
                    end else if (k == 0 && intvec_i) begin
                        off = 32'h200;
                        m_pc_tag <= "R4";
                    end else if ((k == 2 || k == 3) && refill_i) begin
                        off = stat_exl_i ? 32'h180 : 32'h0;
                        m_pc_tag <= "R5";
                    end else begin
                        off = 32'h180;
                        m_pc_tag <= "R3";
                    end
                    m_taken <= 1;
                    m_pc <= base + off;
                    m_code <= exc_kind_i;
                    if (!stat_exl_i) begin
                        m_epc <= ra;
                        m_bd <= in_dslot_i;
                        m_tag <= "R1";
                    end else begin
                        m_tag <= "R2";
                    end
                    m_exl <= 1; m_erl <= stat_erl_i; m_bev <= stat_bev_i; m_dm <= stat_dm_i;
                end else if (k == 16 || k == 17) begin
                    m_taken <= 1; m_pc <= 32'hBFC00000; m_errpc <= ra;
                    m_exl <= stat_exl_i; m_erl <= 1; m_bev <= 1; m_dm <= stat_dm_i;
                    m_tag <= "R8"; m_pc_tag <= "R8";
                end else if (k == 18) begin
                    m_taken <= 1; m_pc <= 32'hBFC00480; m_dpc <= ra;
                    m_exl <= stat_exl_i; m_erl <= stat_erl_i; m_bev <= stat_bev_i; m_dm <= 1;
                    m_tag <= "R9"; m_pc_tag <= "R9";
                end
            end
        end
    end

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R11", "taken", {31'd0, taken_o}, {31'd0, m_taken});
        chk(m_pc_tag, "next_pc", next_pc_o, m_pc);
        chk(m_tag, "epc", epc_o, m_epc);
        chk(m_tag, "errpc", errpc_o, m_errpc);
        chk(m_tag, "dpc", dpc_o, m_dpc);
        chk(m_tag, "exl", {31'd0, exl_o}, {31'd0, m_exl});
        chk(m_tag, "erl", {31'd0, erl_o}, {31'd0, m_erl});
        chk(m_tag, "bev", {31'd0, bev_o}, {31'd0, m_bev});
        chk(m_tag, "dm", {31'd0, dm_o}, {31'd0, m_dm});
        chk(m_tag, "bd", {31'd0, bd_o}, {31'd0, m_bd});
        chk("R7", "code", {27'd0, code_o}, {27'd0, m_code});
    endtask

    task automatic drive(input bit v, input int k, input logic [31:0] pc, input bit ds, input bit rf,
                         input bit exl, input bit erl, input bit bev, input bit dm, input bit iv,
                         input logic [21:0] vb);
        exc_valid_i = v; exc_kind_i = 5'(k); cur_pc_i = pc; in_dslot_i = ds; refill_i = rf;
        stat_exl_i = exl; stat_erl_i = erl; stat_bev_i = bev; stat_dm_i = dm; intvec_i = iv;
        vec_base_i = vb;
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        compare_all();
        // R1: plain general exception, no delay slot
        drive(1, 8, 32'h0000_1000, 0, 0, 0, 0, 0, 0, 0, 22'h20_0001);
        step();
        // R2: above exception level, epc held
        drive(1, 4, 32'h0000_2000, 1, 0, 1, 0, 0, 0, 0, 22'h20_0001);
        step();
        // R4: vectored interrupt
        drive(1, 0, 32'h0000_3000, 0, 0, 0, 0, 1, 0, 1, 22'h0);
        step();
        // R5: refill at both levels
        drive(1, 2, 32'h0000_4000, 1, 1, 0, 0, 0, 0, 0, 22'h3F_FFFF);
        step();
        drive(1, 3, 32'h0000_4004, 0, 1, 1, 0, 0, 0, 0, 22'h3F_FFFF);
        step();
        // R6: cache error both bootstrap settings
        drive(1, 30, 32'h0000_5000, 0, 0, 0, 0, 1, 0, 0, 22'h1);
        step();
        drive(1, 30, 32'h0000_5000, 0, 0, 0, 0, 0, 0, 0, 22'h1);
        step();
        // R8: NMI from a delay slot at PC zero wraps
        drive(1, 16, 32'h0, 1, 0, 0, 0, 0, 0, 0, 22'h0);
        step();
        // R9: debug
        drive(1, 18, 32'h0000_6000, 1, 0, 0, 0, 0, 0, 0, 22'h0);
        step();
        // R10: unknown kinds
        drive(1, 14, 32'h0000_7000, 1, 1, 0, 0, 0, 0, 1, 22'h5);
        step();
        drive(1, 31, 32'h0000_7000, 1, 1, 0, 0, 0, 0, 1, 22'h5);
        step();
        // R11: idle holds
        drive(0, 8, 32'h0000_8000, 0, 0, 0, 0, 0, 0, 0, 22'h0);
        step();
        // mixed patterns
        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 4) != 0, int'($urandom % 32),
                  (($urandom % 16) == 0) ? 32'h0 : ($urandom & 32'hFFFF_FFFC),
                  $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                  $urandom % 2, $urandom % 2, $urandom % 2, 22'($urandom));
            step();
        end
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule